// File: doc/BRIEF.md
# Multi-Mode DSP Address Generator

This block produces a 32-bit effective address for one memory channel of a streaming DSP datapath. Software loads three base registers and a pair of window-limit registers (lower and upper bound) through a register-write port. Each command from the command decoder supplies an addressing mode, a step size, a 12-bit immediate offset, a base-register select and an FFT size. A flag in the command says whether the address restarts from the chosen base plus the offset.

After a command starts, each pulse on the advance strobe from the pipeline moves the address one step. The step is linear up or down by the step size, circular inside the window, or bit-reversed over an FFT of 2^m points. A channel uses one instance, so two operand-read channels and one result-write channel take three copies. The address is a registered output. It changes on the clock edge after the event that moves it.

Top module: `mm_addr_gen`

## Requirements
- R1: A register write with `reg_wr_sel` 0, 1 or 2 loads that base register, 3 loads the window lower bound and 4 loads the window upper bound. A register write never changes `addr_out` by itself.
- R2: On `cmd_start` with `cmd_addr_upd`=1, `addr_out` becomes base[`cmd_base_sel`] plus the zero-extended `cmd_offset` on the next edge. A select value of 3 picks base 0. The bit-reverse index restarts at 0.
- R3: On `cmd_start` with `cmd_addr_upd`=0, `addr_out` keeps its value. The new mode and step govern later advances.
- R4: In mode 1, each advance adds `cmd_step` to the address, modulo 2^32.
- R5: In mode 2, each advance subtracts `cmd_step` from the address, modulo 2^32.
- R6: In mode 3, each advance adds the step. If the sum S passes the upper bound E, the result is lower + (S − E − 1).
- R7: In mode 4, each advance subtracts the step. If the difference D falls below the lower bound L, the result is upper − (L − D − 1).
- R8: In mode 5, an index counts 1, 2, … modulo 2^m on each advance, where m = `cmd_fft_log2`. The address is origin + 4 × (index with its low m bits reversed), where origin is the last update address.
- R9: In modes 0, 6 and 7, an advance leaves `addr_out` unchanged.
- R10: When `cmd_start` and `advance` are high in the same cycle, the command wins and the advance is dropped.
- R11: After synchronous reset, `addr_out` is 0, every register is 0 and the mode is hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select: 0-2 base, 3 lower bound, 4 upper bound |
| reg_wr_data | input | 32 | Register write data |
| cmd_start | input | 1 | Command start pulse |
| cmd_mode | input | 3 | Addressing mode code |
| cmd_addr_upd | input | 1 | Reinitialise address from base plus offset |
| cmd_offset | input | 12 | Immediate address offset |
| cmd_step | input | 4 | Step size for linear and circular modes |
| cmd_base_sel | input | 2 | Base register select |
| cmd_fft_log2 | input | 4 | log2 of FFT points for bit-reverse mode |
| advance | input | 1 | Move to the next address |
| addr_out | output | 32 | Current effective address (registered) |

## Verification
Wrong internal state shows up on `addr_out` one edge after the advance or command that uses it. A wrong latched step or mode gives a wrong next value straight away. A bad wrap comparison only shows on the advance that crosses a window limit. The tests therefore cross each limit with a step that overshoots by a known amount. A corrupted bit-reverse index breaks the permutation at the first odd position, and a wrong index mask shows only at the 2^m wrap. The bit-reverse test therefore runs a full period and one step past it.

// File: rtl/mm_addr_gen_pkg.sv
package mm_addr_gen_pkg;

  typedef enum logic [2:0] {
    MD_HOLD = 3'd0,
    MD_INC  = 3'd1,
    MD_DEC  = 3'd2,
    MD_CINC = 3'd3,
    MD_CDEC = 3'd4,
    MD_BREV = 3'd5,
    MD_FIR  = 3'd6,
    MD_RSV  = 3'd7
  } agu_mode_e;

  function automatic logic mode_moves(agu_mode_e m);
    return (m == MD_INC) || (m == MD_DEC) || (m == MD_CINC) ||
           (m == MD_CDEC) || (m == MD_BREV);
  endfunction

endpackage

// File: rtl/mag_reg_bank.sv
module mag_reg_bank #(
  parameter int AW   = 32,
  parameter int NB   = 3,
  parameter int SELW = 3,
  parameter int BSW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic [BSW-1:0]  base_sel,
  output logic [AW-1:0]   base_val,
  output logic [AW-1:0]   lo_val,
  output logic [AW-1:0]   hi_val
);

  localparam logic [SELW-1:0] LO_CODE = SELW'(NB);
  localparam logic [SELW-1:0] HI_CODE = SELW'(NB + 1);

  logic [AW-1:0] base_r [NB];
  logic [AW-1:0] lo_r;
  logic [AW-1:0] hi_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) base_r[i] <= '0;
      lo_r <= '0;
      hi_r <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NB; i++)
        if (wr_sel == SELW'(i)) base_r[i] <= wr_data;
      if (wr_sel == LO_CODE) lo_r <= wr_data;
      if (wr_sel == HI_CODE) hi_r <= wr_data;
    end
  end

  always_comb begin
    base_val = base_r[0];
    for (int i = 0; i < NB; i++)
      if (base_sel == BSW'(i)) base_val = base_r[i];
  end

  assign lo_val = lo_r;
  assign hi_val = hi_r;

  // R1
  lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == LO_CODE) |=> (lo_val == $past(wr_data)));

  // R1
  hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == HI_CODE) |=> (hi_val == $past(wr_data)));

endmodule

// File: rtl/mag_bit_rev.sv
module mag_bit_rev #(
  parameter int IW  = 12,
  parameter int MSW = 4
) (
  input  logic [IW-1:0]  idx,
  input  logic [MSW-1:0] m,
  output logic [IW-1:0]  rev
);

  always_comb begin
    rev = '0;
    for (int i = 0; i < IW; i++)
      for (int j = 0; j < IW; j++)
        if ((i < int'(m)) && (j == int'(m) - 1 - i))
          rev[i] = idx[j];
  end

endmodule

// File: rtl/mag_next_addr.sv
module mag_next_addr
  import mm_addr_gen_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SW  = 4,
  parameter int IW  = 12
) (
  input  agu_mode_e       mode,
  input  logic [AW-1:0]   cur,
  input  logic [SW-1:0]   step,
  input  logic [AW-1:0]   lo,
  input  logic [AW-1:0]   hi,
  input  logic [AW-1:0]   origin,
  input  logic [IW-1:0]   rev_idx,
  output logic [AW-1:0]   nxt
);

  localparam int EW = AW + 2;
  localparam logic signed [EW-1:0] ONE = EW'(1);

  logic signed [EW-1:0] cur_s, step_s, lo_s, hi_s;
  logic signed [EW-1:0] sum_s, dif_s, tmp_s;
  logic [AW-1:0] rev_ofs;

  always_comb begin
    cur_s  = $signed({2'b00, cur});
    step_s = $signed({{(EW-SW){1'b0}}, step});
    lo_s   = $signed({2'b00, lo});
    hi_s   = $signed({2'b00, hi});
    sum_s  = cur_s + step_s;
    dif_s  = cur_s - step_s;
    rev_ofs = '0;
    rev_ofs[IW+1:0] = {rev_idx, 2'b00};
    tmp_s  = cur_s;
    case (mode)
      MD_INC:  tmp_s = sum_s;
      MD_DEC:  tmp_s = dif_s;
      MD_CINC: tmp_s = (sum_s > hi_s) ? (lo_s + (sum_s - hi_s - ONE)) : sum_s;
      MD_CDEC: tmp_s = (dif_s < lo_s) ? (hi_s - (lo_s - dif_s - ONE)) : dif_s;
      default: tmp_s = cur_s;
    endcase
    if (mode == MD_BREV) nxt = origin + rev_ofs;
    else                 nxt = tmp_s[AW-1:0];
  end

endmodule

// File: rtl/mm_addr_gen.sv
module mm_addr_gen
  import mm_addr_gen_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFSW = 12,
  parameter int SW   = 4,
  parameter int NB   = 3,
  parameter int IW   = 12,
  parameter int MSW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr_en,
  input  logic [2:0]      reg_wr_sel,
  input  logic [AW-1:0]   reg_wr_data,
  input  logic            cmd_start,
  input  logic [2:0]      cmd_mode,
  input  logic            cmd_addr_upd,
  input  logic [OFSW-1:0] cmd_offset,
  input  logic [SW-1:0]   cmd_step,
  input  logic [1:0]      cmd_base_sel,
  input  logic [MSW-1:0]  cmd_fft_log2,
  input  logic            advance,
  output logic [AW-1:0]   addr_out
);

  localparam logic [MSW-1:0] M_CAP = MSW'(IW);

  logic [AW-1:0]  base_val, lo_val, hi_val;
  logic [AW-1:0]  init_addr, nxt_addr;
  logic [AW-1:0]  addr_q, origin_q;
  logic [IW-1:0]  idx_q, idx_nxt, idx_mask, rev_idx;
  logic [SW-1:0]  step_q;
  logic [MSW-1:0] m_q, m_eff;
  agu_mode_e      mode_q;

  mag_reg_bank #(.AW(AW), .NB(NB), .SELW(3), .BSW(2)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .base_sel(cmd_base_sel),
    .base_val(base_val), .lo_val(lo_val), .hi_val(hi_val)
  );

  assign init_addr = base_val + {{(AW-OFSW){1'b0}}, cmd_offset};

  always_comb begin
    m_eff = (m_q > M_CAP) ? M_CAP : m_q;
    idx_mask = '0;
    for (int i = 0; i < IW; i++)
      if (i < int'(m_eff)) idx_mask[i] = 1'b1;
    idx_nxt = (idx_q + IW'(1)) & idx_mask;
  end

  mag_bit_rev #(.IW(IW), .MSW(MSW)) u_rev (
    .idx(idx_nxt), .m(m_eff), .rev(rev_idx)
  );

  mag_next_addr #(.AW(AW), .SW(SW), .IW(IW)) u_next (
    .mode(mode_q), .cur(addr_q), .step(step_q),
    .lo(lo_val), .hi(hi_val), .origin(origin_q),
    .rev_idx(rev_idx), .nxt(nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      origin_q <= '0;
      idx_q    <= '0;
      step_q   <= '0;
      m_q      <= '0;
      mode_q   <= MD_HOLD;
    end else if (cmd_start) begin
      mode_q <= agu_mode_e'(cmd_mode);
      step_q <= cmd_step;
      m_q    <= cmd_fft_log2;
      if (cmd_addr_upd) begin
        addr_q   <= init_addr;
        origin_q <= init_addr;
        idx_q    <= '0;
      end
    end else if (advance && mode_moves(mode_q)) begin
      addr_q <= nxt_addr;
      if (mode_q == MD_BREV) idx_q <= idx_nxt;
    end
  end

  assign addr_out = addr_q;

  // R2
  upd_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_addr_upd) |=>
      (addr_out == $past(base_val) + {{(AW-OFSW){1'b0}}, $past(cmd_offset)}));

  // R3
  no_upd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cmd_addr_upd) |=> $stable(addr_out));

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_INC && advance && !cmd_start) |=>
      (addr_out == $past(addr_out) + {{(AW-SW){1'b0}}, $past(step_q)}));

  // R9
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_moves(mode_q) && !cmd_start) |=> $stable(addr_out));

  // R6
  cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == MD_CINC || mode_q == MD_CDEC) && advance && !cmd_start &&
     !reg_wr_en && lo_val <= hi_val && addr_q >= lo_val && addr_q <= hi_val &&
     ({{(AW-SW){1'b0}}, step_q} <= hi_val - lo_val)) |=>
      (addr_out >= lo_val && addr_out <= hi_val));

  // R8
  brev_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_BREV && advance && !cmd_start) |=>
      (idx_q == (($past(idx_q) + IW'(1)) & $past(idx_mask))));

endmodule

// File: tb/mm_addr_gen_bench.sv
module mm_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en;
  logic [2:0]  reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic        cmd_start;
  logic [2:0]  cmd_mode;
  logic        cmd_addr_upd;
  logic [11:0] cmd_offset;
  logic [3:0]  cmd_step;
  logic [1:0]  cmd_base_sel;
  logic [3:0]  cmd_fft_log2;
  logic        advance;
  logic [31:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mm_addr_gen u_mm_addr_gen (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .cmd_start(cmd_start), .cmd_mode(cmd_mode), .cmd_addr_upd(cmd_addr_upd),
    .cmd_offset(cmd_offset), .cmd_step(cmd_step), .cmd_base_sel(cmd_base_sel),
    .cmd_fft_log2(cmd_fft_log2), .advance(advance), .addr_out(addr_out)
  );

  function automatic logic [31:0] ref_cinc(logic [31:0] a, int s, logic [31:0] lo, logic [31:0] hi);
    longint sum = longint'(a) + s;
    if (sum > longint'(hi)) return 32'(longint'(lo) + (sum - longint'(hi) - 1));
    return 32'(sum);
  endfunction

  function automatic logic [31:0] ref_cdec(logic [31:0] a, int s, logic [31:0] lo, logic [31:0] hi);
    longint d = longint'(a) - s;
    if (d < longint'(lo)) return 32'(longint'(hi) - (longint'(lo) - d - 1));
    return 32'(d);
  endfunction

  function automatic int ref_rev(int v, int m);
    int r = 0;
    for (int i = 0; i < m; i++) if (v[i]) r |= (1 << (m - 1 - i));
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] sel, logic [31:0] d);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic start(logic [2:0] mode, logic upd, logic [11:0] ofs,
                       logic [3:0] step, logic [1:0] bsel, logic [3:0] m);
    cmd_start = 1; cmd_mode = mode; cmd_addr_upd = upd; cmd_offset = ofs;
    cmd_step = step; cmd_base_sel = bsel; cmd_fft_log2 = m;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic adv();
    advance = 1;
    @(negedge clk);
    advance = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R11 reset value", addr_out, 32'h0);
    adv();
    check("R11 hold mode after reset", addr_out, 32'h0);
  endtask

  task automatic t_update_linear();
    wr_reg(3'd0, 32'h0000_0100);
    wr_reg(3'd1, 32'h0000_1000);
    wr_reg(3'd2, 32'h0000_2000);
    check("R1 write leaves address", addr_out, 32'h0);
    start(3'd1, 1'b1, 12'h010, 4'd4, 2'd1, 4'd0);
    check("R2 base1 plus offset", addr_out, 32'h0000_1010);
    adv(); check("R4 increment", addr_out, 32'h0000_1014);
    adv(); check("R4 increment again", addr_out, 32'h0000_1018);
    wr_reg(3'd1, 32'h0000_5000);
    check("R1 write mid-run leaves address", addr_out, 32'h0000_1018);
    start(3'd2, 1'b0, 12'hFFF, 4'd3, 2'd0, 4'd0);
    check("R3 no update keeps address", addr_out, 32'h0000_1018);
    adv(); check("R5 decrement", addr_out, 32'h0000_1015);
    start(3'd2, 1'b1, 12'h001, 4'd2, 2'd3, 4'd0);
    check("R2 select 3 picks base0", addr_out, 32'h0000_0101);
    adv(); check("R5 decrement", addr_out, 32'h0000_00FF);
    start(3'd1, 1'b1, 12'h000, 4'd0, 2'd1, 4'd0);
    check("R1 new base1 used by update", addr_out, 32'h0000_5000);
    wr_reg(3'd0, 32'hFFFF_FFFE);
    start(3'd1, 1'b1, 12'h000, 4'd5, 2'd0, 4'd0);
    adv(); check("R4 wraps modulo 2^32", addr_out, 32'h0000_0003);
  endtask

  task automatic t_hold();
    logic [31:0] keep;
    start(3'd0, 1'b0, 12'h0, 4'd7, 2'd0, 4'd0);
    keep = addr_out;
    adv(); check("R9 mode 0 holds", addr_out, keep);
    start(3'd6, 1'b0, 12'h0, 4'd7, 2'd0, 4'd0);
    adv(); check("R9 mode 6 holds", addr_out, keep);
    start(3'd7, 1'b0, 12'h0, 4'd7, 2'd0, 4'd0);
    adv(); check("R9 mode 7 holds", addr_out, keep);
  endtask

  task automatic t_cyclic();
    logic [31:0] exp;
    wr_reg(3'd0, 32'h0000_0100);
    wr_reg(3'd3, 32'h0000_0100);
    wr_reg(3'd4, 32'h0000_010F);
    start(3'd3, 1'b1, 12'h00C, 4'd4, 2'd0, 4'd0);
    exp = 32'h10C;
    check("R6 cyclic start", addr_out, exp);
    adv(); exp = ref_cinc(exp, 4, 32'h100, 32'h10F);
    check("R6 wrap exactly to lower bound", addr_out, 32'h100);
    start(3'd3, 1'b0, 12'h0, 4'd6, 2'd0, 4'd0);
    for (int k = 0; k < 3; k++) begin
      adv(); exp = ref_cinc(exp, 6, 32'h100, 32'h10F);
      check("R6 cyclic increment", addr_out, exp);
    end
    check("R6 overshoot carried", addr_out, 32'h102);
    start(3'd4, 1'b0, 12'h0, 4'd5, 2'd0, 4'd0);
    adv(); exp = ref_cdec(exp, 5, 32'h100, 32'h10F);
    check("R7 undershoot wrap", addr_out, 32'h10D);
    for (int k = 0; k < 4; k++) begin
      adv(); exp = ref_cdec(exp, 5, 32'h100, 32'h10F);
      check("R7 cyclic decrement", addr_out, exp);
    end
  endtask

  task automatic t_bitrev();
    wr_reg(3'd2, 32'h0000_2000);
    start(3'd5, 1'b1, 12'h040, 4'd0, 2'd2, 4'd3);
    check("R8 origin at index 0", addr_out, 32'h0000_2040);
    for (int k = 1; k <= 9; k++) begin
      adv();
      check("R8 bit-reversed address", addr_out,
            32'h2040 + 32'(ref_rev(k % 8, 3) * 4));
    end
  endtask

  task automatic t_priority();
    wr_reg(3'd1, 32'h0000_3000);
    start(3'd1, 1'b1, 12'h000, 4'd8, 2'd1, 4'd0);
    adv(); check("R4 before priority test", addr_out, 32'h0000_3008);
    cmd_start = 1; cmd_mode = 3'd1; cmd_addr_upd = 1; cmd_offset = 12'h004;
    cmd_step = 4'd8; cmd_base_sel = 2'd1; cmd_fft_log2 = 4'd0; advance = 1;
    @(negedge clk);
    cmd_start = 0; advance = 0;
    check("R10 command beats advance", addr_out, 32'h0000_3004);
  endtask

  initial begin
    rst = 1; reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0;
    cmd_start = 0; cmd_mode = 0; cmd_addr_upd = 0; cmd_offset = 0;
    cmd_step = 0; cmd_base_sel = 0; cmd_fft_log2 = 0; advance = 0;
    @(negedge clk);
    t_reset();
    t_update_linear();
    t_hold();
    t_cyclic();
    t_bitrev();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule